// File: doc/BRIEF.md
# Per-Pin GPIO Bank Register File

This block holds the control and status registers for one bank of 32 general-purpose pins, grouped as four ports of eight pins. A single-cycle write strobe with an address and data word reaches eight register groups per port: pin enable, output enable, output level, synchronized input level, interrupt status, interrupt enable, interrupt sense type and a write-one-to-clear interrupt acknowledge. Reads are combinational from the current address.

Every writable group except the acknowledge register also has a second, masked address. A write there carries a per-pin write-enable in the byte above the data byte, so one pin can be changed without a read-modify-write sequence and without disturbing its neighbours. The block drives the pin output levels and output enables, passes the sense type on to a separate edge/level detector, accepts that detector's per-pin event pulses into sticky status bits, and raises one pending line per port.

The bank's position in the address map is set by a bank index and a bank stride. The distance from the plain registers to the masked aliases is set by a separate offset. Both common layouts are supported: stride 0x100 with aliases 0x80 above, and stride 0x80 with aliases 0x800 above.

Top module: `gpio_bank_regs`

## Requirements
- R1: After reset, pin enable, output enable, output level, interrupt enable, sense type and interrupt status are all zero for every pin, so every pin_oe bit is 0.
- R2: A plain write to bank base + group*0x10 + port*4, with group 0 pin enable, 1 output enable, 2 output level, 5 interrupt enable or 6 sense type, loads wdata[7:0] into that port only. A read of the address returns the register in bits 7:0 and zero above.
- R3: A write to a masked alias changes pin k to wdata[k] only when wdata[8+k] is 1; a pin whose enable bit is 0 keeps its value.
- R4: The masked aliases of groups 0, 1, 2, 5 and 6 sit UPPER_OFS above the plain address. A read there returns the plain register's value in bits 7:0.
- R5: pin_out carries the output-level registers. pin_oe bit n is 1 only when both the pin enable bit and the output enable bit of pin n are 1.
- R6: The input group (3) returns the pin levels after a two-flop synchronizer, so a pin change is first visible two rising edges later. Writes to this group change no register.
- R7: An irq_evt pulse on pin n sets that pin's status bit, which stays set until it is acknowledged.
- R8: Writing 1 to bit k of the acknowledge group (7) clears status bit k of that port. Zero bits leave status unchanged, and an event arriving in the same cycle as its clear leaves the bit set.
- R9: Writes to the status group (4) change nothing. The acknowledge group reads as zero.
- R10: irq_pend[p] is 1 exactly when port p has a status bit set whose interrupt-enable bit is also 1.
- R11: Addresses outside both windows of this bank, addresses with nonzero bits 1:0, and masked addresses of groups 3, 4 and 7 write nothing and read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Single-cycle write strobe |
| bus_addr | input | ADDR_W | Byte address |
| bus_wdata | input | DATA_W | Write data: bits 7:0 values, bits 15:8 per-pin enables on masked writes |
| bus_rdata | output | DATA_W | Read data for bus_addr, combinational |
| pin_in | input | 32 | Asynchronous pin levels |
| irq_evt | input | 32 | Per-pin event pulses from the detector |
| pin_out | output | 32 | Output level per pin |
| pin_oe | output | 32 | Output enable per pin, gated by pin enable |
| irq_sense | output | 32 | Sense type bits per pin, for the detector |
| irq_pend | output | 4 | Per-port pending interrupt |

## Verification
Directed stimulus separates a plain write from a masked write on the same port. It covers a masked write whose enable byte mixes set and clear pins, a masked write with an empty enable byte, and plain writes that must leave the neighbouring ports untouched. Status traffic covers acknowledge words of all zeros, a clear of a set bit, and a clear that coincides with a new event, which separates clear-first from event-first priority. After that, several hundred cycles of random addresses fall into the plain window, the alias window, misaligned slots and foreign addresses. They run with sparse events and changing pin levels, and the bench compares every output against a behavioural model on each clock.

// File: rtl/gpio_bank_pkg.sv
package gpio_bank_pkg;

   // Register groups; the value is address bits [6:4] inside a window.
   typedef enum logic [2:0] {
      GRP_CFG  = 3'd0,
      GRP_OE   = 3'd1,
      GRP_OUT  = 3'd2,
      GRP_IN   = 3'd3,
      GRP_STA  = 3'd4,
      GRP_IE   = 3'd5,
      GRP_TYPE = 3'd6,
      GRP_CLR  = 3'd7
   } reg_grp_e;

   typedef struct packed {
      logic     hit;
      logic     masked;
      reg_grp_e grp;
      logic [1:0] port;
   } bus_sel_t;

   localparam int unsigned GRP_SPAN   = 'h10;
   localparam int unsigned WINDOW     = 8 * GRP_SPAN;
   localparam int unsigned PORT_SLOTS = GRP_SPAN / 4;
   localparam int unsigned NUM_WR     = 5;

   function automatic logic has_alias(reg_grp_e g);
      return (g == GRP_CFG) || (g == GRP_OE) || (g == GRP_OUT) ||
             (g == GRP_IE)  || (g == GRP_TYPE);
   endfunction

   function automatic reg_grp_e wr_grp(int i);
      case (i)
         0:       return GRP_CFG;
         1:       return GRP_OE;
         2:       return GRP_OUT;
         3:       return GRP_IE;
         default: return GRP_TYPE;
      endcase
   endfunction

endpackage

// File: rtl/gpio_addr_decode.sv
module gpio_addr_decode
   import gpio_bank_pkg::*;
#(
   parameter int unsigned ADDR_W      = 12,
   parameter int unsigned NUM_PORTS   = 4,
   parameter int unsigned BANK_IDX    = 0,
   parameter int unsigned BANK_STRIDE = 'h100,
   parameter int unsigned UPPER_OFS   = 'h80
)(
   input  logic [ADDR_W-1:0] addr,
   output bus_sel_t          sel
);
   localparam int unsigned BASE_INT = BANK_IDX * BANK_STRIDE;
   localparam logic [ADDR_W-1:0] PLAIN_BASE = ADDR_W'(BASE_INT);
   localparam logic [ADDR_W-1:0] ALIAS_BASE = ADDR_W'(BASE_INT + UPPER_OFS);
   localparam logic [ADDR_W-1:0] WIN        = ADDR_W'(WINDOW);

   if (ADDR_W < 8) begin : g_bad_aw
      $error("address too narrow for one register window");
   end
   if (BANK_STRIDE < WINDOW) begin : g_bad_stride
      $error("bank stride smaller than one register window");
   end
   if (UPPER_OFS < WINDOW) begin : g_bad_upper
      $error("alias offset overlaps the plain window");
   end
   if (BASE_INT + UPPER_OFS + WINDOW > (1 << ADDR_W)) begin : g_bad_map
      $error("bank windows exceed the address space");
   end

   logic [ADDR_W-1:0] plain_off, alias_off, off;
   logic              in_plain, in_alias, port_ok;
   reg_grp_e          grp;
   logic              unused_off_hi;

   assign plain_off     = addr - PLAIN_BASE;
   assign alias_off     = addr - ALIAS_BASE;
   assign in_plain      = plain_off < WIN;
   assign in_alias      = alias_off < WIN;
   assign off           = in_plain ? plain_off : alias_off;
   assign grp           = reg_grp_e'(off[6:4]);
   assign port_ok       = 32'(off[3:2]) < NUM_PORTS;
   assign unused_off_hi = ^off[ADDR_W-1:7];

   always_comb begin
      sel.grp    = grp;
      sel.port   = off[3:2];
      sel.masked = !in_plain;
      sel.hit    = (in_plain || (in_alias && has_alias(grp))) &&
                   (off[1:0] == 2'b00) && port_ok;
   end

   // R11
   always_comb begin
      misalign_chk: assert (!(sel.hit && (addr[1:0] != 2'b00)));
   end

endmodule

// File: rtl/gpio_in_sync.sv
module gpio_in_sync #(
   parameter int unsigned WIDTH  = 32,
   parameter int unsigned STAGES = 2
)(
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] din,
   output logic [WIDTH-1:0] dout
);
   if (STAGES < 2) begin : g_bad_stages
      $error("synchronizer needs at least two stages");
   end

   logic [STAGES-1:0][WIDTH-1:0] stg;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stg <= '0;
      else        stg <= {stg[STAGES-2:0], din};
   end

   assign dout = stg[STAGES-1];

   // R6
   sync_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $past(rst_n) |-> (stg[0] == $past(din)));

   // R6
   sync_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $past(rst_n) |-> (dout == $past(stg[STAGES-2])));

endmodule

// File: rtl/gpio_port_regs.sv
module gpio_port_regs
   import gpio_bank_pkg::*;
#(
   parameter int unsigned PINS = 8
)(
   input  logic            clk,
   input  logic            rst_n,
   input  logic            wr_en,
   input  logic            port_sel,
   input  logic            masked,
   input  reg_grp_e        grp,
   input  logic [PINS-1:0] wval,
   input  logic [PINS-1:0] wmask,
   input  logic [PINS-1:0] evt,
   input  logic [PINS-1:0] pin_sync,
   output logic [PINS-1:0] cfg_q,
   output logic [PINS-1:0] oe_q,
   output logic [PINS-1:0] out_q,
   output logic [PINS-1:0] type_q,
   output logic [PINS-1:0] rd_val,
   output logic            pend
);
   logic [NUM_WR-1:0][PINS-1:0] wr_q;
   logic [PINS-1:0]             ie_q, sta_q, clr_bits;

   for (genvar i = 0; i < NUM_WR; i++) begin : g_wr
      localparam reg_grp_e G = wr_grp(i);
      logic            hit;
      logic [PINS-1:0] q;
      assign hit = wr_en && port_sel && (grp == G);
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)      q <= '0;
         else if (hit)    q <= masked ? ((q & ~wmask) | (wval & wmask)) : wval;
      end
      assign wr_q[i] = q;
   end

   assign cfg_q  = wr_q[0];
   assign oe_q   = wr_q[1];
   assign out_q  = wr_q[2];
   assign ie_q   = wr_q[3];
   assign type_q = wr_q[4];

   assign clr_bits = (wr_en && port_sel && !masked && (grp == GRP_CLR)) ? wval : '0;

   // event wins over a coincident clear so no event is lost
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sta_q <= '0;
      else        sta_q <= (sta_q & ~clr_bits) | evt;
   end

   always_comb begin
      case (grp)
         GRP_CFG:  rd_val = cfg_q;
         GRP_OE:   rd_val = oe_q;
         GRP_OUT:  rd_val = out_q;
         GRP_IN:   rd_val = pin_sync;
         GRP_STA:  rd_val = sta_q;
         GRP_IE:   rd_val = ie_q;
         GRP_TYPE: rd_val = type_q;
         default:  rd_val = '0;
      endcase
   end

   assign pend = |(sta_q & ie_q);

   // R3
   masked_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && port_sel && masked && (grp == GRP_OUT)) |=>
      ((out_q & ~$past(wmask)) == ($past(out_q) & ~$past(wmask))));

   // R7
   sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (evt != '0) |=> ((sta_q & $past(evt)) == $past(evt)));

   // R8
   clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && port_sel && !masked && (grp == GRP_CLR)) |=>
      ((sta_q & $past(wval) & ~$past(evt)) == '0));

   // R9
   sta_wr_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && port_sel && (grp == GRP_STA) && (evt == '0)) |=> $stable(sta_q));

endmodule

// File: rtl/gpio_bank_regs.sv
module gpio_bank_regs
   import gpio_bank_pkg::*;
#(
   parameter int unsigned ADDR_W      = 12,
   parameter int unsigned DATA_W      = 32,
   parameter int unsigned NUM_PORTS   = 4,
   parameter int unsigned PINS        = 8,
   parameter int unsigned BANK_IDX    = 0,
   parameter int unsigned BANK_STRIDE = 'h100,
   parameter int unsigned UPPER_OFS   = 'h80,
   parameter int unsigned SYNC_STAGES = 2
)(
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      bus_wr,
   input  logic [ADDR_W-1:0]         bus_addr,
   input  logic [DATA_W-1:0]         bus_wdata,
   output logic [DATA_W-1:0]         bus_rdata,
   input  logic [NUM_PORTS*PINS-1:0] pin_in,
   input  logic [NUM_PORTS*PINS-1:0] irq_evt,
   output logic [NUM_PORTS*PINS-1:0] pin_out,
   output logic [NUM_PORTS*PINS-1:0] pin_oe,
   output logic [NUM_PORTS*PINS-1:0] irq_sense,
   output logic [NUM_PORTS-1:0]      irq_pend
);
   localparam int unsigned NPINS = NUM_PORTS * PINS;

   if (NUM_PORTS > PORT_SLOTS || NUM_PORTS == 0) begin : g_bad_ports
      $error("port count must fit the four slots of a group");
   end
   if (2 * PINS > DATA_W) begin : g_bad_pins
      $error("data word cannot hold value and enable bytes");
   end

   bus_sel_t sel;
   logic [NPINS-1:0] pin_sync;
   logic [NUM_PORTS-1:0][PINS-1:0] rd_each;
   logic [PINS-1:0] rd_pick;

   gpio_addr_decode #(
      .ADDR_W(ADDR_W), .NUM_PORTS(NUM_PORTS), .BANK_IDX(BANK_IDX),
      .BANK_STRIDE(BANK_STRIDE), .UPPER_OFS(UPPER_OFS)
   ) u_dec (
      .addr(bus_addr), .sel(sel)
   );

   gpio_in_sync #(.WIDTH(NPINS), .STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst_n(rst_n), .din(pin_in), .dout(pin_sync)
   );

   for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
      logic [PINS-1:0] cfg_w, oe_w;
      gpio_port_regs #(.PINS(PINS)) u_port (
         .clk      (clk),
         .rst_n    (rst_n),
         .wr_en    (bus_wr && sel.hit),
         .port_sel (sel.port == 2'(p)),
         .masked   (sel.masked),
         .grp      (sel.grp),
         .wval     (bus_wdata[PINS-1:0]),
         .wmask    (bus_wdata[2*PINS-1:PINS]),
         .evt      (irq_evt[p*PINS +: PINS]),
         .pin_sync (pin_sync[p*PINS +: PINS]),
         .cfg_q    (cfg_w),
         .oe_q     (oe_w),
         .out_q    (pin_out[p*PINS +: PINS]),
         .type_q   (irq_sense[p*PINS +: PINS]),
         .rd_val   (rd_each[p]),
         .pend     (irq_pend[p])
      );
      assign pin_oe[p*PINS +: PINS] = cfg_w & oe_w;
   end

   always_comb begin
      rd_pick = '0;
      for (int p = 0; p < NUM_PORTS; p++) begin
         if (sel.port == 2'(p)) rd_pick = rd_each[p];
      end
   end

   assign bus_rdata = sel.hit ? DATA_W'(rd_pick) : '0;

   if (2 * PINS < DATA_W) begin : g_wdata_hi
      logic unused_wdata_hi;
      assign unused_wdata_hi = ^bus_wdata[DATA_W-1:2*PINS];
   end

endmodule

// File: tb/gpio_bank_regs_test.sv
module gpio_bank_regs_test;
   localparam int BANK   = 2;
   localparam int STRIDE = 'h100;
   localparam int UPPER  = 'h80;
   localparam int PB     = BANK * STRIDE;
   localparam int AB     = PB + UPPER;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bus_wr = 1'b0;
   logic [11:0] bus_addr = '0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic [31:0] pin_in = '0;
   logic [31:0] irq_evt = '0;
   logic [31:0] pin_out, pin_oe, irq_sense;
   logic [3:0]  irq_pend;

   int n_chk = 0;
   int n_bad = 0;

   gpio_bank_regs #(
      .ADDR_W(12), .DATA_W(32), .NUM_PORTS(4), .PINS(8),
      .BANK_IDX(BANK), .BANK_STRIDE(STRIDE), .UPPER_OFS(UPPER), .SYNC_STAGES(2)
   ) uut (
      .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pin_in(pin_in),
      .irq_evt(irq_evt), .pin_out(pin_out), .pin_oe(pin_oe),
      .irq_sense(irq_sense), .irq_pend(irq_pend)
   );

   always #4 clk = ~clk;

   // ---------------- behavioural reference model ----------------
   int m_cfg[4], m_oe[4], m_out[4], m_ie[4], m_ty[4], m_sta[4];
   int s1 = 0, s2 = 0;

   function automatic void dec(input int a, output bit h, output bit mk,
                               output int g, output int p);
      int off;
      h = 0; mk = 0; g = 0; p = 0;
      if (a >= PB && a < PB + 'h80) off = a - PB;
      else if (a >= AB && a < AB + 'h80) begin off = a - AB; mk = 1; end
      else return;
      g = off / 16;
      p = (off % 16) / 4;
      if (off % 4 != 0) return;
      if (mk && !(g == 0 || g == 1 || g == 2 || g == 5 || g == 6)) return;
      h = 1;
   endfunction

   function automatic int apply(int cur, bit mk, int d);
      int v = d & 'hFF;
      int m = (d >> 8) & 'hFF;
      return mk ? (((cur & ~m) | (v & m)) & 'hFF) : v;
   endfunction

   function automatic int mread(int a);
      bit h, mk; int g, p;
      dec(a, h, mk, g, p);
      if (!h) return 0;
      case (g)
         0: return m_cfg[p];
         1: return m_oe[p];
         2: return m_out[p];
         3: return (s2 >> (8 * p)) & 'hFF;
         4: return m_sta[p];
         5: return m_ie[p];
         6: return m_ty[p];
         default: return 0;
      endcase
   endfunction

   task automatic model_step();
      bit h, mk; int g, p;
      int clr_p = -1;
      int clr_v = 0;
      if (!rst_n) begin
         for (int q = 0; q < 4; q++) begin
            m_cfg[q] = 0; m_oe[q] = 0; m_out[q] = 0; m_ie[q] = 0; m_ty[q] = 0; m_sta[q] = 0;
         end
         s1 = 0; s2 = 0;
         return;
      end
      s2 = s1;
      s1 = int'(pin_in);
      dec(int'(bus_addr), h, mk, g, p);
      if (bus_wr && h) begin
         case (g)
            0: m_cfg[p] = apply(m_cfg[p], mk, int'(bus_wdata));
            1: m_oe[p]  = apply(m_oe[p],  mk, int'(bus_wdata));
            2: m_out[p] = apply(m_out[p], mk, int'(bus_wdata));
            5: m_ie[p]  = apply(m_ie[p],  mk, int'(bus_wdata));
            6: m_ty[p]  = apply(m_ty[p],  mk, int'(bus_wdata));
            7: begin clr_p = p; clr_v = int'(bus_wdata[7:0]); end
            default: ;
         endcase
      end
      for (int q = 0; q < 4; q++)
         m_sta[q] = ((m_sta[q] & ~((q == clr_p) ? clr_v : 0)) |
                     int'(irq_evt[q*8 +: 8])) & 'hFF;
   endtask

   task automatic cmp(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %08h expected %08h at %0t", tag, act, exp, $time);
      end
   endtask

   always @(posedge clk) begin
      logic [31:0] e_out, e_oe, e_ty;
      logic [3:0]  e_pend;
      model_step();
      #2;
      for (int q = 0; q < 4; q++) begin
         e_out[q*8 +: 8] = 8'(m_out[q]);
         e_oe[q*8 +: 8]  = 8'(m_cfg[q] & m_oe[q]);
         e_ty[q*8 +: 8]  = 8'(m_ty[q]);
         e_pend[q]       = (m_sta[q] & m_ie[q]) != 0;
      end
      cmp("R2 model rdata", bus_rdata, 32'(mread(int'(bus_addr))));
      cmp("R5 model pin_out", pin_out, e_out);
      cmp("R5 model pin_oe", pin_oe, e_oe);
      cmp("R2 model irq_sense", irq_sense, e_ty);
      cmp("R10 model irq_pend", {28'd0, irq_pend}, {28'd0, e_pend});
   end

   // ---------------- directed stimulus ----------------
   task automatic wr(input int a, input int d);
      @(negedge clk);
      bus_wr = 1'b1; bus_addr = 12'(a); bus_wdata = 32'(d);
      @(negedge clk);
      bus_wr = 1'b0; bus_addr = '0; bus_wdata = '0;
   endtask

   task automatic rd_check(input string tag, input int a, input int exp);
      @(negedge clk);
      bus_addr = 12'(a);
      #1;
      cmp(tag, bus_rdata, 32'(exp));
   endtask

   task automatic port_check(input string tag, input logic [31:0] act, input logic [31:0] exp);
      @(negedge clk);
      #1;
      cmp(tag, act, exp);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      rd_check("R1 cfg port0 after reset", PB + 'h00, 0);
      rd_check("R1 sta port3 after reset", PB + 'h4C, 0);
      port_check("R1 pin_oe after reset", pin_oe, 32'h0);

      wr(PB + 'h04, 'hFFFF_FF5A);
      rd_check("R2 cfg port1 upper bits zero", PB + 'h04, 'h5A);
      rd_check("R2 cfg port0 untouched", PB + 'h00, 0);

      wr(PB + 'h28, 'h0F);
      wr(AB + 'h28, 'h3CF0);
      rd_check("R3 masked out port2", PB + 'h28, 'h33);
      rd_check("R4 alias read out port2", AB + 'h28, 'h33);
      wr(AB + 'h28, 'h00FF);
      rd_check("R3 empty mask keeps out", PB + 'h28, 'h33);

      wr(AB + 'h60, 'h8181);
      port_check("R3 masked sense port0", irq_sense, 32'h0000_0081);
      wr(PB + 'h6C, 'h1234_00C3);
      port_check("R2 plain sense port3", irq_sense, 32'hC300_0081);

      wr(PB + 'h08, 'h0F);
      wr(PB + 'h18, 'hFF);
      port_check("R5 pin_oe gated by enable", pin_oe, 32'h000F_0000);
      port_check("R5 pin_out level", pin_out, 32'h0033_0000);

      @(negedge clk) pin_in = 32'hA5C3_1234;
      rd_check("R6 one edge not yet visible", PB + 'h3C, 0);
      rd_check("R6 visible after two edges", PB + 'h3C, 'hA5);
      rd_check("R6 port0 input", PB + 'h30, 'h34);
      wr(PB + 'h3C, 'hFF);
      rd_check("R6 write to input ignored", PB + 'h3C, 'hA5);
      port_check("R6 write to input leaves outputs", pin_out, 32'h0033_0000);

      @(negedge clk) irq_evt = 32'h0000_0100;
      @(negedge clk) irq_evt = 32'h0;
      rd_check("R7 status set", PB + 'h44, 'h01);
      rd_check("R7 status other port clear", PB + 'h40, 0);
      rd_check("R7 status still set", PB + 'h44, 'h01);
      port_check("R10 no pend without enable", {28'd0, irq_pend}, 32'h0);
      wr(PB + 'h54, 'h01);
      port_check("R10 pend with enable", {28'd0, irq_pend}, 32'h2);

      wr(PB + 'h74, 'h00);
      rd_check("R8 zero ack no effect", PB + 'h44, 'h01);
      wr(PB + 'h74, 'h01);
      rd_check("R8 ack clears", PB + 'h44, 0);
      port_check("R10 pend drops", {28'd0, irq_pend}, 32'h0);
      @(negedge clk);
      bus_wr = 1'b1; bus_addr = 12'(PB + 'h74); bus_wdata = 32'h02; irq_evt = 32'h0000_0200;
      @(negedge clk);
      bus_wr = 1'b0; bus_addr = '0; bus_wdata = '0; irq_evt = '0;
      rd_check("R8 event beats clear", PB + 'h44, 'h02);

      wr(PB + 'h44, 'h00);
      rd_check("R9 status write ignored", PB + 'h44, 'h02);
      rd_check("R9 ack reads zero", PB + 'h74, 0);

      wr(AB + 'h44, 'hFF00);
      rd_check("R11 no alias for status", PB + 'h44, 'h02);
      rd_check("R11 input alias reads zero", AB + 'h30, 0);
      wr('h100, 'hFF);
      wr(PB + 'h01, 'hFF);
      wr(AB + 'h80, 'hFF);
      rd_check("R11 foreign and misaligned writes", PB + 'h00, 0);
      rd_check("R11 misaligned read zero", PB + 'h01, 0);

      // random traffic, checked by the model each clock
      for (int i = 0; i < 600; i++) begin
         int sel_w, a;
         @(negedge clk);
         sel_w = int'($urandom % 16);
         a = ((sel_w < 8) ? PB : AB) + int'($urandom % 8) * 16 + int'($urandom % 4) * 4;
         if (sel_w == 15) a = a + 1 + int'($urandom % 3);
         if (sel_w == 14) a = int'($urandom % 4096);
         bus_wr    = ($urandom % 3) != 0;
         bus_addr  = 12'(a);
         bus_wdata = $urandom;
         irq_evt   = (($urandom % 6) == 0) ? (32'h1 << ($urandom % 32)) : 32'h0;
         if (($urandom % 5) == 0) pin_in = $urandom;
      end
      @(negedge clk);
      bus_wr = 1'b0; irq_evt = '0;
      repeat (3) @(negedge clk);

      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

   initial begin
      #(8 * 200000);
      n_bad++;
      $display("FAIL watchdog: actual run still active, expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

endmodule